// File: doc/BRIEF.md
# Multi-drop bus receive address filter

This block sits on a UART receive path between the shift register that assembles each word and the receive FIFO. Each word arrives with a mode bit: 1 marks an address word and 0 marks a data word. When multi-drop bus operation is on, the block keeps data words out of the FIFO until an address word has been seen. A sticky address flag that software clears records that an address word was seen. When multi-drop bus operation is off, every word passes through.

The block registers the push to the FIFO, so an accepted word appears on the FIFO side one cycle after its valid strobe. It also keeps an address status bit that follows the type of the last accepted word. It drives an interrupt line that is the sticky flag gated by an enable.

Top module: `mdb_rx_filter`

## Requirements
- R1: After reset, `fifo_push_o`, `fifo_data_o`, `addr_o`, `addr_sticky_o` and `addr_irq_o` are all 0.
- R2: An accepted word gives a single-cycle `fifo_push_o` pulse in the cycle after its `rx_valid_i` cycle, and `fifo_data_o` carries the word unchanged. Every push matches an accepted word, and pushes come in arrival order.
- R3: With `mdb_en_i` = 0, every word is accepted whatever its mode bit.
- R4: With `mdb_en_i` = 1 and the sticky flag clear, a word with mode bit 0 is discarded. It gives no push and leaves `addr_o` and `addr_sticky_o` unchanged.
- R5: With `mdb_en_i` = 1 and the sticky flag clear, a word with mode bit 1 is accepted. The same clock edge that registers its push also sets `addr_sticky_o`.
- R6: While `addr_sticky_o` is 1, every word is accepted whatever its mode bit.
- R7: `addr_o` is updated on each accepted word, to 1 for mode bit 1 and to 0 for mode bit 0.
- R8: `addr_sticky_o` is set by any accepted word with mode bit 1. It is cleared only by a cycle with `csr_wr_i` = 1 and `csr_wdata_i[1]` = 1 (write-1-to-clear). A write with `csr_wdata_i[1]` = 0 leaves it unchanged.
- R9: When a clearing write and an accepted address word fall in the same cycle, `addr_sticky_o` stays 1.
- R10: `addr_irq_o` equals `addr_sticky_o` AND `addr_irq_en_i`, so it falls when the sticky flag is cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| rx_valid_i | input | 1 | Received word strobe, one cycle per word |
| rx_data_i | input | DATA_W | Received word |
| rx_mode_i | input | 1 | Mode bit: 1 address word, 0 data word |
| mdb_en_i | input | 1 | Multi-drop bus filtering enable |
| addr_irq_en_i | input | 1 | Address-word interrupt enable |
| csr_wr_i | input | 1 | Status register write strobe |
| csr_wdata_i | input | CSR_W | Status write data; bit 1 is write-1-to-clear for the sticky flag |
| fifo_push_o | output | 1 | Push to the receive FIFO |
| fifo_data_o | output | DATA_W | Word to push |
| addr_o | output | 1 | Type of the last accepted word |
| addr_sticky_o | output | 1 | Sticky address-seen flag |
| addr_irq_o | output | 1 | Address-word interrupt |

## Verification
The bench builds the block with DATA_W = 9 and CSR_W = 8. The wider word lets a unique sequence tag travel in every pushed word, so a discarded word that leaks into the FIFO, or a reordered push, shows up as a scoreboard mismatch. CSR_W = 8 leaves room to write the other status bits without bit 1 and show that those writes do not touch the sticky flag. The sequences cover a clear sticky flag, a set sticky flag and a disabled filter, including a clearing write that lands in the same cycle as an address word.

// File: rtl/mdb_pkg.sv
package mdb_pkg;
  localparam int unsigned STICKY_CLR_BIT = 1;

  typedef enum logic [1:0] {
    ACC_DROP   = 2'd0,
    ACC_BYPASS = 2'd1,
    ACC_STICKY = 2'd2,
    ACC_ADDR   = 2'd3
  } accept_e;
endpackage

// File: rtl/mdb_accept_gate.sv
module mdb_accept_gate
  import mdb_pkg::*;
(
  input  logic    rx_valid_i,
  input  logic    rx_mode_i,
  input  logic    mdb_en_i,
  input  logic    sticky_i,
  output logic    accept_o,
  output accept_e reason_o
);
  always_comb begin
    reason_o = ACC_DROP;
    if (!mdb_en_i)      reason_o = ACC_BYPASS;
    else if (sticky_i)  reason_o = ACC_STICKY;
    else if (rx_mode_i) reason_o = ACC_ADDR;
    accept_o = rx_valid_i && (reason_o != ACC_DROP);
  end
endmodule

// File: rtl/mdb_status_regs.sv
module mdb_status_regs
  import mdb_pkg::*;
#(
  parameter int unsigned CSR_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             accept_i,
  input  logic             mode_i,
  input  logic             csr_wr_i,
  input  logic [CSR_W-1:0] csr_wdata_i,
  output logic             addr_o,
  output logic             sticky_o
);
  logic clr_req;
  logic set_req;

  assign clr_req = csr_wr_i && csr_wdata_i[STICKY_CLR_BIT];
  assign set_req = accept_i && mode_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_o   <= 1'b0;
      sticky_o <= 1'b0;
    end else begin
      if (accept_i) addr_o <= mode_i;
      // set wins over a same-cycle clear
      if (set_req)      sticky_o <= 1'b1;
      else if (clr_req) sticky_o <= 1'b0;
    end
  end

  // R5 / R8: accepted address word sets the flag
  a_r5_sticky_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (accept_i && mode_i) |=> sticky_o);
  // R8: only a clearing write drops the flag
  a_r8_sticky_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sticky_o && !(csr_wr_i && csr_wdata_i[STICKY_CLR_BIT])) |=> sticky_o);
  // R9: clear and set in one cycle keep it set
  a_r9_set_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (csr_wr_i && csr_wdata_i[STICKY_CLR_BIT] && accept_i && mode_i) |=> sticky_o);
  // R4: no accept leaves addr status stable
  a_r4_addr_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !accept_i |=> $stable(addr_o));
endmodule

// File: rtl/mdb_push_stage.sv
module mdb_push_stage #(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              accept_i,
  input  logic [DATA_W-1:0] data_i,
  output logic              push_o,
  output logic [DATA_W-1:0] data_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      push_o <= 1'b0;
      data_o <= '0;
    end else begin
      push_o <= accept_i;
      if (accept_i) data_o <= data_i;
    end
  end

  // R2: push follows accept by one cycle with the same word
  a_r2_push_data: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept_i |=> (push_o && data_o == $past(data_i)));
  a_r2_no_spurious: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !accept_i |=> !push_o);
endmodule

// File: rtl/mdb_rx_filter.sv
module mdb_rx_filter
  import mdb_pkg::*;
#(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned CSR_W  = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rx_valid_i,
  input  logic [DATA_W-1:0] rx_data_i,
  input  logic              rx_mode_i,
  input  logic              mdb_en_i,
  input  logic              addr_irq_en_i,
  input  logic              csr_wr_i,
  input  logic [CSR_W-1:0]  csr_wdata_i,
  output logic              fifo_push_o,
  output logic [DATA_W-1:0] fifo_data_o,
  output logic              addr_o,
  output logic              addr_sticky_o,
  output logic              addr_irq_o
);
  logic    accept;
  accept_e reason;

  mdb_accept_gate u_gate (
    .rx_valid_i (rx_valid_i),
    .rx_mode_i  (rx_mode_i),
    .mdb_en_i   (mdb_en_i),
    .sticky_i   (addr_sticky_o),
    .accept_o   (accept),
    .reason_o   (reason)
  );

  mdb_status_regs #(.CSR_W(CSR_W)) u_status (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .accept_i    (accept),
    .mode_i      (rx_mode_i),
    .csr_wr_i    (csr_wr_i),
    .csr_wdata_i (csr_wdata_i),
    .addr_o      (addr_o),
    .sticky_o    (addr_sticky_o)
  );

  mdb_push_stage #(.DATA_W(DATA_W)) u_push (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .accept_i (accept),
    .data_i   (rx_data_i),
    .push_o   (fifo_push_o),
    .data_o   (fifo_data_o)
  );

  assign addr_irq_o = addr_sticky_o & addr_irq_en_i;

  // R3: filter off passes every word
  a_r3_bypass: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_valid_i && !mdb_en_i) |=> fifo_push_o);
  // R6: sticky set passes every word
  a_r6_sticky_pass: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_valid_i && addr_sticky_o) |=> fifo_push_o);
  // R4: data word dropped while filtering and flag clear
  a_r4_drop: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_valid_i && mdb_en_i && !addr_sticky_o && !rx_mode_i) |=> !fifo_push_o);
  // R10: interrupt is never raised without the flag
  a_r10_irq_src: assert property (@(posedge clk_i) disable iff (!rst_ni)
    addr_irq_o |-> addr_sticky_o);
endmodule

// File: tb/mdb_rx_filter_tb_top.sv
module mdb_rx_filter_tb_top;
  localparam int unsigned DATA_W = 9;
  localparam int unsigned CSR_W  = 8;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              rx_valid = 1'b0;
  logic [DATA_W-1:0] rx_data = '0;
  logic              rx_mode = 1'b0;
  logic              mdb_en = 1'b0;
  logic              irq_en = 1'b0;
  logic              csr_wr = 1'b0;
  logic [CSR_W-1:0]  csr_wdata = '0;
  logic              fifo_push;
  logic [DATA_W-1:0] fifo_data;
  logic              addr_st;
  logic              sticky;
  logic              irq;

  int checks = 0;
  int errors = 0;
  logic [DATA_W-1:0] exp_q[$];

  logic m_sticky = 1'b0;
  logic m_addr = 1'b0;
  logic [DATA_W-1:0] seq = '0;

  always #5 clk = ~clk;

  mdb_rx_filter #(.DATA_W(DATA_W), .CSR_W(CSR_W)) dut_i (
    .clk_i         (clk),
    .rst_ni        (rst_n),
    .rx_valid_i    (rx_valid),
    .rx_data_i     (rx_data),
    .rx_mode_i     (rx_mode),
    .mdb_en_i      (mdb_en),
    .addr_irq_en_i (irq_en),
    .csr_wr_i      (csr_wr),
    .csr_wdata_i   (csr_wdata),
    .fifo_push_o   (fifo_push),
    .fifo_data_o   (fifo_data),
    .addr_o        (addr_st),
    .addr_sticky_o (sticky),
    .addr_irq_o    (irq)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // monitor: pop and compare on each push (R2)
  always @(negedge clk) begin
    if (rst_n && fifo_push) begin
      checks++;
      if (exp_q.size() == 0) begin
        errors++;
        $display("FAIL R2/R4: actual push %0h expected no push", fifo_data);
      end else begin
        logic [DATA_W-1:0] e;
        e = exp_q.pop_front();
        if (fifo_data !== e) begin
          errors++;
          $display("FAIL R2: actual %0h expected %0h", fifo_data, e);
        end
      end
    end
  end

  // one word, optional same-cycle write; then status checks
  task automatic send(input logic mode, input logic wr, input logic [CSR_W-1:0] wd,
                      input string req);
    logic acc;
    @(negedge clk);
    seq = seq + 1'b1;
    rx_valid = 1'b1; rx_mode = mode; rx_data = seq;
    csr_wr = wr; csr_wdata = wd;
    acc = !mdb_en || m_sticky || mode;
    if (acc) begin
      exp_q.push_back(seq);
      m_addr = mode;
    end
    if (acc && mode) m_sticky = 1'b1;
    else if (wr && wd[1]) m_sticky = 1'b0;
    @(posedge clk);
    @(negedge clk);
    rx_valid = 1'b0; csr_wr = 1'b0; csr_wdata = '0;
    check({req, " addr_o"}, 32'(addr_st), 32'(m_addr));
    check({req, " sticky"}, 32'(sticky), 32'(m_sticky));
    check({req, " R10 irq"}, 32'(irq), 32'(m_sticky & irq_en));
  endtask

  task automatic csr_write(input logic [CSR_W-1:0] wd, input string req);
    @(negedge clk);
    csr_wr = 1'b1; csr_wdata = wd;
    if (wd[1]) m_sticky = 1'b0;
    @(negedge clk);
    csr_wr = 1'b0; csr_wdata = '0;
    check({req, " sticky"}, 32'(sticky), 32'(m_sticky));
    check({req, " R10 irq"}, 32'(irq), 32'(m_sticky & irq_en));
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin : stim
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 push", 32'(fifo_push), 0);
    check("R1 data", 32'(fifo_data), 0);
    check("R1 addr", 32'(addr_st), 0);
    check("R1 sticky", 32'(sticky), 0);
    check("R1 irq", 32'(irq), 0);
    rst_n = 1'b1;

    // R3 filter off
    mdb_en = 1'b0;
    send(1'b0, 1'b0, '0, "R3");
    send(1'b1, 1'b0, '0, "R3");
    send(1'b0, 1'b0, '0, "R3/R7");
    csr_write(8'h02, "R8 clear");

    // R4 filter on, data dropped
    mdb_en = 1'b1; irq_en = 1'b1;
    send(1'b0, 1'b0, '0, "R4");
    send(1'b0, 1'b0, '0, "R4");
    // R5 address accepted, sets sticky
    send(1'b1, 1'b0, '0, "R5");
    // R6 data passes while sticky
    send(1'b0, 1'b0, '0, "R6/R7");
    send(1'b0, 1'b0, '0, "R6");
    // R8 write without bit1 keeps sticky
    csr_write(8'hFD, "R8 nonclear");
    csr_write(8'h02, "R8 clear");
    send(1'b0, 1'b0, '0, "R4 after clear");
    // R9 clear and address same cycle
    send(1'b1, 1'b0, '0, "R5");
    send(1'b1, 1'b1, 8'h02, "R9");
    send(1'b0, 1'b0, '0, "R9 data passes");
    // R10 irq gated by enable
    irq_en = 1'b0;
    @(negedge clk);
    check("R10 irq off", 32'(irq), 0);
    irq_en = 1'b1;
    @(negedge clk);
    check("R10 irq on", 32'(irq), 1);
    // data word with clear in same cycle while sticky: accepted, then clear
    send(1'b0, 1'b1, 8'h02, "R6/R8");
    send(1'b0, 1'b0, '0, "R4");
    // back-to-back mixed
    for (int i = 0; i < 6; i++) send(logic'(i % 3 == 1), 1'b0, '0, "R2 mix");

    repeat (3) @(negedge clk);
    check("R2 queue empty", 32'(exp_q.size()), 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule